// File: doc/BRIEF.md
# Privileged Control Register Bank

This block holds the 32-bit privileged control registers of a processor core and serves the two coprocessor move operations from the integer pipeline. A register is named by a 5-bit number and a 3-bit select. Writes take the low 32 bits of a general register. Reads return the 32-bit value sign-extended to the general-register width.

Each register follows its own write rule. Some registers are fully writable. Some have fixed write masks or forced bits. Some are read-only or have write side effects. A register/select pair that is not implemented reads as zero, and a write to it changes nothing. The block also supplies a pseudo-random replacement index, read back through the random register, and a one-cycle pulse that clears the pending timer interrupt whenever the compare register is written.

Top module: `sysreg_file`

## Requirements
- R1: Register 12 select 0 (status) and select 1 (interrupt control) store all 32 written bits. Register 12 select 2 always reads zero and ignores writes.
- R2: Register 15 select 0 always reads the parameter PRID_VALUE, and writes to it have no effect.
- R3: A write to register 15 select 1 (exception base) stores (value AND 32'h3FFF_F000) OR 32'h8000_0000.
- R4: Register 16 selects are gated by the bitmap CFG_USABLE, where bit k enables select k. Select 0 changes only bits 1:0 on a write and keeps bits 31:2. Other usable selects read CFG_RO_VALUE and ignore writes. Selects that are not usable read zero.
- R5: Writes to register 1 (random) and register 6 (wired) are ignored. Wired reads zero.
- R6: Register 1 select 0 reads a value in the range 0 to TLB_ENTRIES-1, and this value changes over time.
- R7: A write to register 11 select 0 (compare) stores the value. timer_clr is high for exactly the one cycle after that write edge and is low at every other time.
- R8: A write to register 23 select 0 (debug) changes only the bits set in DBG_WMASK.
- R9: Every other register stores a write at select 0 only. Any nonzero select of such a register reads zero, and a write to it leaves all state unchanged.
- R10: rd_data is the 32-bit register value sign-extended to GPR_W bits. A write uses only wr_data[31:0].
- R11: After reset, status, interrupt control, debug, compare and the generic registers read zero, the exception base reads 32'h8000_0000, and register 16 select 0 reads CFG0_RESET.
- R12: Reads are combinational. A write becomes visible on rd_data in the cycle after the clock edge that takes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Move-to request for this cycle |
| wr_reg | input | 5 | Register number of the write |
| wr_sel | input | 3 | Select of the write |
| wr_data | input | GPR_W | Source general register; only bits 31:0 are used |
| rd_reg | input | 5 | Register number of the read |
| rd_sel | input | 3 | Select of the read |
| rd_data | output | GPR_W | Sign-extended read result |
| timer_clr | output | 1 | One-cycle pulse that clears the pending timer interrupt |

## Verification
A read result is due in the same cycle as its address, because the read path has no register. A write is due one cycle later: it shows up on rd_data after the clock edge that takes it. timer_clr is also due in that cycle after the write edge. The bench drives inputs on the falling edge and samples two nanoseconds later. It keeps a reference model that it updates on each rising edge, so every comparison sees the state left by all earlier writes. The random register cannot be predicted, so it is checked for range and for change over time instead of for an exact value.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;
  typedef logic [4:0]  regnum_t;
  typedef logic [2:0]  sel_t;
  typedef logic [31:0] word_t;

  localparam int NREG = 32;

  localparam regnum_t REG_RANDOM  = 5'd1;
  localparam regnum_t REG_WIRED   = 5'd6;
  localparam regnum_t REG_COMPARE = 5'd11;
  localparam regnum_t REG_STATUS  = 5'd12;
  localparam regnum_t REG_PRID    = 5'd15;
  localparam regnum_t REG_CONFIG  = 5'd16;
  localparam regnum_t REG_DEBUG   = 5'd23;

  localparam word_t EBASE_KEEP  = 32'h3FFF_F000;
  localparam word_t EBASE_FORCE = 32'h8000_0000;
  localparam word_t CFG0_WMASK  = 32'h0000_0003;
endpackage

// File: rtl/sysreg_lfsr.sv
module sysreg_lfsr #(
  parameter int          TLB_ENTRIES = 16,
  parameter int          LFSR_W      = 16,
  parameter logic [15:0] TAPS        = 16'hB400,
  parameter logic [15:0] SEED        = 16'hACE1,
  localparam int         IDX_W       = $clog2(TLB_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [IDX_W-1:0] idx_o
);
  logic [LFSR_W-1:0] lfsr_q, lfsr_d;

  always_comb begin
    lfsr_d = {1'b0, lfsr_q[LFSR_W-1:1]};
    if (lfsr_q[0]) lfsr_d = lfsr_d ^ TAPS[LFSR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= SEED[LFSR_W-1:0];
    else        lfsr_q <= lfsr_d;
  end

  assign idx_o = IDX_W'(lfsr_q % LFSR_W'(TLB_ENTRIES));
endmodule

// File: rtl/sysreg_wr_dec.sv
module sysreg_wr_dec
  import sysreg_pkg::*;
#(
  parameter logic [7:0] CFG_USABLE = 8'h03,
  parameter word_t      DBG_WMASK  = 32'h1230_0F00
) (
  input  logic    wr_en,
  input  regnum_t wr_reg,
  input  sel_t    wr_sel,
  input  word_t   wr_word,
  input  word_t   old_word,
  output logic    gen_we,
  output word_t   gen_wdata,
  output logic    intctl_we,
  output logic    ebase_we,
  output word_t   ebase_wdata,
  output logic    clr_d
);
  logic sel0;
  assign sel0 = (wr_sel == 3'd0);

  always_comb begin
    gen_we      = 1'b0;
    gen_wdata   = wr_word;
    intctl_we   = 1'b0;
    ebase_we    = 1'b0;
    ebase_wdata = (wr_word & EBASE_KEEP) | EBASE_FORCE;
    clr_d       = 1'b0;
    if (wr_en) begin
      unique case (wr_reg)
        REG_RANDOM, REG_WIRED: ;
        REG_STATUS: begin
          gen_we    = sel0;
          intctl_we = (wr_sel == 3'd1);
        end
        REG_PRID:    ebase_we = (wr_sel == 3'd1);
        REG_CONFIG: begin
          gen_we    = sel0 && CFG_USABLE[0];
          gen_wdata = (old_word & ~CFG0_WMASK) | (wr_word & CFG0_WMASK);
        end
        REG_DEBUG: begin
          gen_we    = sel0;
          gen_wdata = (old_word & ~DBG_WMASK) | (wr_word & DBG_WMASK);
        end
        REG_COMPARE: begin
          gen_we = sel0;
          clr_d  = sel0;
        end
        default:     gen_we = sel0;
      endcase
    end
  end
endmodule

// File: rtl/sysreg_rd_mux.sv
module sysreg_rd_mux
  import sysreg_pkg::*;
#(
  parameter int         TLB_ENTRIES  = 16,
  parameter word_t      PRID_VALUE   = 32'h0001_8765,
  parameter word_t      CFG_RO_VALUE = 32'h9E19_0C8A,
  parameter logic [7:0] CFG_USABLE   = 8'h03,
  localparam int        IDX_W        = $clog2(TLB_ENTRIES)
) (
  input  regnum_t          rd_reg,
  input  sel_t             rd_sel,
  input  word_t            regs_i [NREG],
  input  word_t            intctl_i,
  input  word_t            ebase_i,
  input  logic [IDX_W-1:0] rand_i,
  output word_t            rd_word
);
  always_comb begin
    rd_word = '0;
    unique case (rd_reg)
      REG_RANDOM: if (rd_sel == 3'd0) rd_word = 32'(rand_i);
      REG_STATUS: begin
        if (rd_sel == 3'd0)      rd_word = regs_i[REG_STATUS];
        else if (rd_sel == 3'd1) rd_word = intctl_i;
      end
      REG_PRID: begin
        if (rd_sel == 3'd0)      rd_word = PRID_VALUE;
        else if (rd_sel == 3'd1) rd_word = ebase_i;
      end
      REG_CONFIG: begin
        if (CFG_USABLE[rd_sel])
          rd_word = (rd_sel == 3'd0) ? regs_i[REG_CONFIG] : CFG_RO_VALUE;
      end
      default: if (rd_sel == 3'd0) rd_word = regs_i[rd_reg];
    endcase
  end
endmodule

// File: rtl/sysreg_file.sv
module sysreg_file
  import sysreg_pkg::*;
#(
  parameter int         GPR_W        = 64,
  parameter int         TLB_ENTRIES  = 16,
  parameter word_t      PRID_VALUE   = 32'h0001_8765,
  parameter word_t      CFG0_RESET   = 32'h8000_0482,
  parameter word_t      CFG_RO_VALUE = 32'h9E19_0C8A,
  parameter logic [7:0] CFG_USABLE   = 8'h03,
  parameter word_t      DBG_WMASK    = 32'h1230_0F00,
  localparam int        IDX_W        = $clog2(TLB_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [4:0]       wr_reg,
  input  logic [2:0]       wr_sel,
  input  logic [GPR_W-1:0] wr_data,
  input  logic [4:0]       rd_reg,
  input  logic [2:0]       rd_sel,
  output logic [GPR_W-1:0] rd_data,
  output logic             timer_clr
);
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  word_t            regs_q [NREG];
  word_t            intctl_q, ebase_q;
  logic             gen_we, intctl_we, ebase_we, clr_d;
  word_t            gen_wdata, ebase_wdata, rd_word;
  logic [IDX_W-1:0] rand_idx;

  sysreg_wr_dec #(.CFG_USABLE(CFG_USABLE), .DBG_WMASK(DBG_WMASK)) u_wr_dec (
    .wr_en(wr_en), .wr_reg(wr_reg), .wr_sel(wr_sel), .wr_word(wr_data[31:0]),
    .old_word(regs_q[wr_reg]), .gen_we(gen_we), .gen_wdata(gen_wdata),
    .intctl_we(intctl_we), .ebase_we(ebase_we), .ebase_wdata(ebase_wdata),
    .clr_d(clr_d)
  );

  sysreg_lfsr #(.TLB_ENTRIES(TLB_ENTRIES)) u_lfsr (
    .clk(clk), .rst_n(rst_i_n), .idx_o(rand_idx)
  );

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      for (int i = 0; i < NREG; i++)
        regs_q[i] <= (i == int'(REG_CONFIG)) ? CFG0_RESET : '0;
    end else if (gen_we) begin
      regs_q[wr_reg] <= gen_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)       intctl_q <= '0;
    else if (intctl_we) intctl_q <= wr_data[31:0];
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)      ebase_q <= EBASE_FORCE;
    else if (ebase_we) ebase_q <= ebase_wdata;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) timer_clr <= 1'b0;
    else          timer_clr <= clr_d;
  end

  sysreg_rd_mux #(
    .TLB_ENTRIES(TLB_ENTRIES), .PRID_VALUE(PRID_VALUE),
    .CFG_RO_VALUE(CFG_RO_VALUE), .CFG_USABLE(CFG_USABLE)
  ) u_rd_mux (
    .rd_reg(rd_reg), .rd_sel(rd_sel), .regs_i(regs_q), .intctl_i(intctl_q),
    .ebase_i(ebase_q), .rand_i(rand_idx), .rd_word(rd_word)
  );

  generate
    if (GPR_W > 32) begin : g_sext
      assign rd_data = {{(GPR_W-32){rd_word[31]}}, rd_word};
    end else begin : g_plain
      assign rd_data = rd_word;
    end
  endgenerate
endmodule

// File: rtl/sysreg_file_chk.sv
module sysreg_file_chk #(
  parameter int          GPR_W       = 64,
  parameter int          TLB_ENTRIES = 16,
  parameter logic [31:0] PRID_VALUE  = 32'h0001_8765
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [4:0]       wr_reg,
  input logic [2:0]       wr_sel,
  input logic [4:0]       rd_reg,
  input logic [2:0]       rd_sel,
  input logic [GPR_W-1:0] rd_data,
  input logic             timer_clr
);
  p_srs_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_reg == 5'd12 && rd_sel == 3'd2) |-> rd_data == '0);

  p_prid_const_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_reg == 5'd15 && rd_sel == 3'd0) |-> rd_data[31:0] == PRID_VALUE);

  p_ebase_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_reg == 5'd15 && rd_sel == 3'd1) |-> (rd_data[31:30] == 2'b10 && rd_data[11:0] == 12'h0));

  p_random_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_reg == 5'd1 && rd_sel == 3'd0) |-> rd_data[31:0] < 32'(TLB_ENTRIES));

  p_clr_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_reg == 5'd11 && wr_sel == 3'd0) |=> timer_clr);

  p_clr_only_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    timer_clr |-> $past(wr_en && wr_reg == 5'd11 && wr_sel == 3'd0));

  p_sext_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[GPR_W-1:31] == '0 || rd_data[GPR_W-1:31] == '1);
endmodule

bind sysreg_file sysreg_file_chk #(
  .GPR_W(GPR_W), .TLB_ENTRIES(TLB_ENTRIES), .PRID_VALUE(PRID_VALUE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_reg(wr_reg), .wr_sel(wr_sel),
  .rd_reg(rd_reg), .rd_sel(rd_sel), .rd_data(rd_data), .timer_clr(timer_clr)
);

// File: tb/sysreg_file_tb_top.sv
`timescale 1ns/1ps
module sysreg_file_tb_top;
  localparam int          W     = 64;
  localparam int          NTLB  = 16;
  localparam logic [31:0] PRID  = 32'h0001_8765;
  localparam logic [31:0] CFG0R = 32'h8000_0482;
  localparam logic [31:0] CFGRO = 32'h9E19_0C8A;
  localparam logic [7:0]  USE   = 8'h03;
  localparam logic [31:0] DMASK = 32'h1230_0F00;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [4:0]   wr_reg = '0, rd_reg = '0;
  logic [2:0]   wr_sel = '0, rd_sel = '0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic         timer_clr;

  int total = 0, bad = 0;
  bit live = 1'b0;

  always #5 clk = ~clk;

  sysreg_file #(.GPR_W(W), .TLB_ENTRIES(NTLB), .PRID_VALUE(PRID), .CFG0_RESET(CFG0R),
    .CFG_RO_VALUE(CFGRO), .CFG_USABLE(USE), .DBG_WMASK(DMASK)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_reg(wr_reg), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_reg(rd_reg), .rd_sel(rd_sel), .rd_data(rd_data),
    .timer_clr(timer_clr));

  // behavioural reference model
  logic [31:0] m_gen [32];
  logic [31:0] m_ic, m_eb;
  bit          m_clr;

  function automatic void m_reset();
    foreach (m_gen[i]) m_gen[i] = 32'h0;
    m_gen[16] = CFG0R;
    m_ic = 0; m_eb = 32'h8000_0000; m_clr = 0;
  endfunction

  function automatic logic [31:0] m_read(int r, int s);
    if (r == 12) return s == 0 ? m_gen[12] : (s == 1 ? m_ic : 32'h0);
    if (r == 15) return s == 0 ? PRID : (s == 1 ? m_eb : 32'h0);
    if (r == 16) return !USE[s] ? 32'h0 : (s == 0 ? m_gen[16] : CFGRO);
    return s == 0 ? m_gen[r] : 32'h0;
  endfunction

  function automatic string req_of(int r, int s);
    case (r)
      12: return "R1";
      15: return s == 0 ? "R2" : "R3";
      16: return "R4";
      6:  return "R5";
      11: return "R7";
      23: return "R8";
      default: return "R9";
    endcase
  endfunction

  initial m_reset();

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else begin
      logic [31:0] v;
      v = wr_data[31:0];
      m_clr = 0;
      if (wr_en) begin
        case (int'(wr_reg))
          1, 6: ;
          12: begin if (wr_sel == 0) m_gen[12] = v; else if (wr_sel == 1) m_ic = v; end
          15: if (wr_sel == 1) m_eb = {2'b10, v[29:12], 12'h0};
          16: if (wr_sel == 0 && USE[0]) m_gen[16] = {m_gen[16][31:2], v[1:0]};
          23: if (wr_sel == 0) m_gen[23] = (m_gen[23] & ~DMASK) | (v & DMASK);
          11: if (wr_sel == 0) begin m_gen[11] = v; m_clr = 1; end
          default: if (wr_sel == 0) m_gen[wr_reg] = v;
        endcase
      end
    end
  end

  function automatic void note(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endfunction

  // per-cycle comparison against the model (R10 sign extension, R12 timing)
  always @(negedge clk) begin
    #2;
    if (live) begin
      logic [W-1:0] e;
      note(timer_clr == m_clr, "R7", W'(timer_clr), W'(m_clr));
      if (rd_reg == 5'd1 && rd_sel == 3'd0)
        note(rd_data < W'(NTLB), "R6", rd_data, W'(NTLB - 1));
      else begin
        e = W'($signed(m_read(rd_reg, rd_sel)));
        note(rd_data == e, {req_of(rd_reg, rd_sel), "/R10/R12"}, rd_data, e);
      end
    end
  end

  task automatic wr(int r, int s, logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_reg = 5'(r); wr_sel = 3'(s); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_chk(int r, int s, logic [W-1:0] exp, string req);
    @(negedge clk);
    rd_reg = 5'(r); rd_sel = 3'(s);
    #2;
    note(rd_data == exp, req, rd_data, exp);
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    live = 1;
    // R11 reset values
    rd_chk(12, 0, 0, "R11");
    rd_chk(15, 1, 64'hFFFF_FFFF_8000_0000, "R11");
    rd_chk(16, 0, 64'hFFFF_FFFF_8000_0482, "R11");
    rd_chk(23, 0, 0, "R11");
    // R1
    wr(12, 0, 64'h0000_0000_1357_9BDF);
    rd_chk(12, 0, 64'h1357_9BDF, "R1");
    wr(12, 1, 64'h0000_0000_0246_8ACE);
    rd_chk(12, 1, 64'h0246_8ACE, "R1");
    wr(12, 2, 64'h0000_0000_FFFF_FFFF);
    rd_chk(12, 2, 0, "R1");
    // R2
    wr(15, 0, 64'h0000_0000_DEAD_BEEF);
    rd_chk(15, 0, 64'(PRID), "R2");
    // R3
    wr(15, 1, 64'h0000_0000_7FFF_FFFF);
    rd_chk(15, 1, 64'hFFFF_FFFF_BFFF_F000, "R3");
    wr(15, 1, 64'h0000_0000_0000_0FFF);
    rd_chk(15, 1, 64'hFFFF_FFFF_8000_0000, "R3");
    // R4
    wr(16, 0, 64'h0000_0000_0000_0000);
    rd_chk(16, 0, 64'hFFFF_FFFF_8000_0480, "R4");
    wr(16, 0, 64'h0000_0000_FFFF_FFFF);
    rd_chk(16, 0, 64'hFFFF_FFFF_8000_0483, "R4");
    wr(16, 1, 64'h0000_0000_0000_0000);
    rd_chk(16, 1, 64'hFFFF_FFFF_9E19_0C8A, "R4");
    rd_chk(16, 5, 0, "R4");
    // R5
    wr(6, 0, 64'h0000_0000_0000_0007);
    rd_chk(6, 0, 0, "R5");
    wr(1, 0, 64'h0000_0000_0000_0100);
    // R6: range and change over time
    begin
      logic [NTLB-1:0] seen = '0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk); rd_reg = 1; rd_sel = 0; #2;
        note(rd_data < W'(NTLB), "R6", rd_data, W'(NTLB - 1));
        if (rd_data < W'(NTLB)) seen[rd_data[3:0]] = 1'b1;
      end
      note($countones(seen) > 1, "R6", W'($countones(seen)), 2);
    end
    // R7
    wr(11, 0, 64'h0000_0000_0001_0000);
    rd_chk(11, 0, 64'h0001_0000, "R7");
    note(timer_clr == 0, "R7", W'(timer_clr), 0);
    wr(11, 3, 64'h0000_0000_0000_0055);
    note(timer_clr == 0, "R7", W'(timer_clr), 0);
    // R8
    wr(23, 0, 64'h0000_0000_FFFF_FFFF);
    rd_chk(23, 0, 64'(DMASK), "R8");
    wr(23, 0, 64'h0000_0000_0000_0100);
    rd_chk(23, 0, 64'h0000_0100, "R8");
    // R9
    wr(4, 0, 64'h0000_0000_1234_5678);
    rd_chk(4, 0, 64'h1234_5678, "R9");
    wr(4, 3, 64'h0000_0000_AAAA_AAAA);
    rd_chk(4, 3, 0, "R9");
    rd_chk(4, 0, 64'h1234_5678, "R9");
    // R10
    wr(12, 0, 64'hDEAD_BEEF_8000_0001);
    rd_chk(12, 0, 64'hFFFF_FFFF_8000_0001, "R10");
    // R12: write not visible before its edge
    @(negedge clk);
    rd_reg = 9; rd_sel = 0;
    wr_en = 1; wr_reg = 9; wr_sel = 0; wr_data = 64'h0000_0000_0BAD_F00D;
    #2;
    note(rd_data == 0, "R12", rd_data, 0);
    @(negedge clk);
    wr_en = 0;
    #2;
    note(rd_data == 64'h0BAD_F00D, "R12", rd_data, 64'h0BAD_F00D);
    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule